// File: doc/BRIEF.md
# Clock Fanout Buffer SMBus Control

This block is the digital control section of a six-output differential clock fanout buffer. It decodes SMBus traffic on SCL/SDA into a small bank of byte-wide configuration registers. From those registers and a few hardware pins it drives six output-enable lines, a PLL bandwidth select and a PLL mode select. SCL and SDA are oversampled by the system clock through a two-flop synchroniser before START and STOP are detected. The slave only ever pulls SDA low (open drain), and it changes SDA only while SCL is low.

Four of the outputs are enabled by register bits. The other two, outputs 1 and 4, follow active-low request pins directly. A software-control bit chooses where the PLL settings come from. When it is clear, the bandwidth follows a pin and the PLL stays in zero-delay mode. When it is set, both settings come from register bits.

Transfers use the SMBus block-write and block-read forms. A writable count register sets how many bytes a block read returns after the count byte.

Top module: `smb_clkbuf_ctrl`

## Requirements
- R1: The slave acknowledges the 8-bit address byte 0xDC (write) and 0xDD (read). Any other address byte is not acknowledged, and the rest of that transfer up to the next START or STOP changes no register.
- R2: After reset the registers read as follows: index 0 = 0x03, index 1 = 0x2D, index 2 = 0x00, index 3 = 0x01, index 4 = 0x06, index 5 = 0x06. With both request pins low, all six output enables are 1.
- R3: Register 0 bit 7 selects the source of the PLL settings. When it is 0, bw_sel equals bw_pin and pll_on is 1. When it is 1, bw_sel equals register 0 bit 1 (1 = high bandwidth) and pll_on equals register 0 bit 0 (1 = PLL mode, 0 = bypass).
- R4: Register 1 bits 0, 2, 3 and 5 drive out_en[0], out_en[2], out_en[3] and out_en[5]. A value of 1 enables the output.
- R5: out_en[1] is the inverse of req1_n and out_en[4] is the inverse of req4_n, whatever the register contents.
- R6: The reserved bits (register 0 bits 6..2, register 1 bits 7, 6, 4 and 1, all of register 2) read back the last value written and do not affect any output.
- R7: Registers 3 and 4 are read-only. A write to either is acknowledged and discarded.
- R8: A block write is address+W, a command byte naming the first register index, a count byte, and then data bytes. Every byte is acknowledged. The first `count` data bytes go to consecutive indices. Data bytes beyond the count are acknowledged and discarded.
- R9: A block read is address+W, the command byte, a repeated START, then address+R. The slave sends the count value, then register bytes from the command index upward. Indices above 5 read as 0x00. A NACK from the master ends the transfer.
- R10: Register 5 is writable, and its value is the first byte returned by every block read.
- R11: sda_oe (1 = pull SDA low) rises only while SCL is low, and it is 0 on the cycle after a STOP is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | SMBus clock line level |
| sda_in | input | 1 | SMBus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| req1_n | input | 1 | Active-low enable request for output 1 |
| req4_n | input | 1 | Active-low enable request for output 4 |
| bw_pin | input | 1 | Pin bandwidth select, used when software control is off |
| out_en | output | 6 | Per-output enables, bit i for output i |
| bw_sel | output | 1 | PLL bandwidth select, 1 = high |
| pll_on | output | 1 | 1 = PLL (zero-delay) mode, 0 = bypass (fanout) mode |

## Verification
Block writes are tried with the exact count, with surplus data bytes, with read-only and out-of-range target indices, and with a foreign address. These cases tell acknowledged-and-stored apart from acknowledged-and-dropped. Block reads start at index 0, at a read-only index and near the end of the bank, and use a reduced count, so the count byte, pointer increment and zero fill are each exposed. A behavioural model of the registers and output mapping is compared with the outputs on every clock between transfers while the request and bandwidth pins are toggled. This separates pin-controlled from register-controlled paths in both software-control settings.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    localparam int REG_W        = 8;
    localparam int NUM_REGS     = 6;
    localparam int NUM_OUT      = 6;
    localparam int REQ_A_IDX    = 1;
    localparam int REQ_B_IDX    = 4;
    localparam int BCNT_IDX     = 5;
    localparam logic [7:0] BCNT_RESET  = 8'h06;
    localparam logic [7:0] DEVICE_CODE = 8'h06;
    localparam logic [3:0] VENDOR_CODE = 4'h1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } smb_state_e;

    typedef enum logic [1:0] {
        RL_ADDR,
        RL_CMD,
        RL_CNT,
        RL_DATA
    } rx_role_e;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    typedef struct packed {
        logic       en;
        logic [7:0] addr;
        logic [7:0] data;
    } reg_wr_t;

    typedef struct packed {
        logic sw_ctl;
        logic bw_hi;
        logic pll_en;
    } pll_ctl_t;

    function automatic logic reg_is_rw(input int idx);
        return (idx == 0) || (idx == 1) || (idx == 2) || (idx == BCNT_IDX);
    endfunction

    function automatic logic [7:0] reg_reset(input int idx);
        case (idx)
            0:        return 8'h03;
            1:        return 8'h2D;
            BCNT_IDX: return BCNT_RESET;
            default:  return 8'h00;
        endcase
    endfunction

    function automatic logic out_is_pin(input int idx);
        return (idx == REQ_A_IDX) || (idx == REQ_B_IDX);
    endfunction

endpackage

// File: rtl/cbc_sync.sv
module cbc_sync
    import cbc_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);

    logic [1:0] raw;
    logic [1:0] sync_q;
    logic [1:0] prev_q;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign sync_q[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '1;
        else     prev_q <= sync_q;
    end

    always_comb begin
        ev.scl      = sync_q[0];
        ev.sda      = sync_q[1];
        ev.scl_rise = sync_q[0] & ~prev_q[0];
        ev.scl_fall = ~sync_q[0] & prev_q[0];
        ev.start    = sync_q[0] & prev_q[0] & prev_q[1] & ~sync_q[1];
        ev.stop     = sync_q[0] & prev_q[0] & ~prev_q[1] & sync_q[1];
    end

endmodule

// File: rtl/cbc_smb_slave.sv
module cbc_smb_slave
    import cbc_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR7 = 7'h6E
) (
    input  logic       clk,
    input  logic       rst,
    input  bus_ev_t    ev,
    input  logic [7:0] rd_data,
    input  logic [7:0] byte_count,
    output logic [7:0] rd_addr,
    output reg_wr_t    wr,
    output logic       sda_oe
);

    smb_state_e st;
    rx_role_e   role;
    logic [3:0] bitcnt;
    logic [7:0] shreg;
    logic [7:0] txsh;
    logic [7:0] ptr;
    logic [7:0] wr_left;
    logic       rnw;

    assign rd_addr = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            role    <= RL_ADDR;
            bitcnt  <= '0;
            shreg   <= '0;
            txsh    <= '0;
            ptr     <= '0;
            wr_left <= '0;
            rnw     <= 1'b0;
            sda_oe  <= 1'b0;
            wr      <= '0;
        end else begin
            wr.en <= 1'b0;
            if (ev.start) begin
                st     <= ST_RX;
                role   <= RL_ADDR;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                st     <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (st)
                    ST_RX: begin
                        if (ev.scl_rise && bitcnt != 4'd8) begin
                            shreg  <= {shreg[6:0], ev.sda};
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.scl_fall && bitcnt == 4'd8) begin
                            if (role == RL_ADDR && shreg[7:1] != DEV_ADDR7) begin
                                st <= ST_IDLE;
                            end else begin
                                st     <= ST_RX_ACK;
                                sda_oe <= 1'b1;
                                case (role)
                                    RL_ADDR: begin
                                        rnw <= shreg[0];
                                        if (shreg[0]) txsh <= byte_count;
                                        else          role <= RL_CMD;
                                    end
                                    RL_CMD: begin
                                        ptr  <= shreg;
                                        role <= RL_CNT;
                                    end
                                    RL_CNT: begin
                                        wr_left <= shreg;
                                        role    <= RL_DATA;
                                    end
                                    default: begin
                                        if (wr_left != 8'd0) begin
                                            wr.en   <= 1'b1;
                                            wr.addr <= ptr;
                                            wr.data <= shreg;
                                            ptr     <= ptr + 8'd1;
                                            wr_left <= wr_left - 8'd1;
                                        end
                                    end
                                endcase
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (ev.scl_fall) begin
                            bitcnt <= '0;
                            if (rnw) begin
                                st     <= ST_TX;
                                sda_oe <= ~txsh[7];
                            end else begin
                                st     <= ST_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    ST_TX: begin
                        if (ev.scl_rise) begin
                            bitcnt <= bitcnt + 4'd1;
                        end else if (ev.scl_fall) begin
                            if (bitcnt == 4'd8) begin
                                st     <= ST_TX_ACK;
                                sda_oe <= 1'b0;
                            end else begin
                                txsh   <= {txsh[6:0], 1'b0};
                                sda_oe <= ~txsh[6];
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (ev.scl_rise) begin
                            if (ev.sda) begin
                                st <= ST_IDLE;
                            end else begin
                                txsh <= rd_data;
                                ptr  <= ptr + 8'd1;
                            end
                        end else if (ev.scl_fall) begin
                            st     <= ST_TX;
                            bitcnt <= '0;
                            sda_oe <= ~txsh[7];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R11: the slave starts pulling SDA only during the low phase of SCL
    a_r11_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !ev.scl);

    // R11: a STOP always leaves the line released
    a_r11_stop_release: assert property (@(posedge clk) disable iff (rst)
        ev.stop |=> !sda_oe);

endmodule

// File: rtl/cbc_regs.sv
module cbc_regs
    import cbc_pkg::*;
#(
    parameter logic [3:0] REV_ID = 4'h0
) (
    input  logic               clk,
    input  logic               rst,
    input  reg_wr_t            wr,
    input  logic [7:0]         rd_addr,
    output logic [7:0]         rd_data,
    output logic [7:0]         byte_count,
    output pll_ctl_t           pll_ctl,
    output logic [NUM_OUT-1:0] oe_reg
);

    localparam int IW = $clog2(NUM_REGS);

    logic [7:0] rf [NUM_REGS];

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        if (reg_is_rw(i)) begin : g_rw
            logic [7:0] q;
            always_ff @(posedge clk) begin
                if (rst)
                    q <= reg_reset(i);
                else if (wr.en && wr.addr == 8'(i))
                    q <= wr.data;
            end
            assign rf[i] = q;
        end else if (i == 3) begin : g_id
            assign rf[i] = {REV_ID, VENDOR_CODE};
        end else begin : g_dev
            assign rf[i] = DEVICE_CODE;
        end
    end

    assign rd_data    = (rd_addr < 8'(NUM_REGS)) ? rf[rd_addr[IW-1:0]] : 8'h00;
    assign byte_count = rf[BCNT_IDX];
    assign oe_reg     = rf[1][NUM_OUT-1:0];

    always_comb begin
        pll_ctl.sw_ctl = rf[0][7];
        pll_ctl.bw_hi  = rf[0][1];
        pll_ctl.pll_en = rf[0][0];
    end

    // R4: an enable write lands on the register-controlled enable bits
    a_r4_enable_write: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == 8'd1) |=> ((oe_reg & 6'h2D) == ($past(wr.data[5:0]) & 6'h2D)));

    // R10: a count write takes effect on the next cycle
    a_r10_count_write: assert property (@(posedge clk) disable iff (rst)
        (wr.en && wr.addr == 8'(BCNT_IDX)) |=> (byte_count == $past(wr.data)));

endmodule

// File: rtl/cbc_outmux.sv
module cbc_outmux
    import cbc_pkg::*;
(
    input  pll_ctl_t           pll_ctl,
    input  logic [NUM_OUT-1:0] oe_reg,
    input  logic               req1_n,
    input  logic               req4_n,
    input  logic               bw_pin,
    output logic [NUM_OUT-1:0] out_en,
    output logic               bw_sel,
    output logic               pll_on
);

    logic [NUM_OUT-1:0] pin_req_n;

    always_comb begin
        pin_req_n            = '1;
        pin_req_n[REQ_A_IDX] = req1_n;
        pin_req_n[REQ_B_IDX] = req4_n;
    end

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        if (out_is_pin(i)) begin : g_pin
            assign out_en[i] = ~pin_req_n[i];
        end else begin : g_reg
            assign out_en[i] = oe_reg[i] & pin_req_n[i];
        end
    end

    assign bw_sel = pll_ctl.sw_ctl ? pll_ctl.bw_hi  : bw_pin;
    assign pll_on = pll_ctl.sw_ctl ? pll_ctl.pll_en : 1'b1;

endmodule

// File: rtl/smb_clkbuf_ctrl.sv
module smb_clkbuf_ctrl
    import cbc_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR7   = 7'h6E,
    parameter logic [3:0] REV_ID      = 4'h0,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       sda_oe,
    input  logic       req1_n,
    input  logic       req4_n,
    input  logic       bw_pin,
    output logic [5:0] out_en,
    output logic       bw_sel,
    output logic       pll_on
);

    bus_ev_t            ev;
    reg_wr_t            wr;
    logic [7:0]         rd_addr;
    logic [7:0]         rd_data;
    logic [7:0]         byte_count;
    pll_ctl_t           pll_ctl;
    logic [NUM_OUT-1:0] oe_reg;

    cbc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    cbc_smb_slave #(.DEV_ADDR7(DEV_ADDR7)) u_slave (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .rd_data    (rd_data),
        .byte_count (byte_count),
        .rd_addr    (rd_addr),
        .wr         (wr),
        .sda_oe     (sda_oe)
    );

    cbc_regs #(.REV_ID(REV_ID)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr         (wr),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .byte_count (byte_count),
        .pll_ctl    (pll_ctl),
        .oe_reg     (oe_reg)
    );

    cbc_outmux u_outmux (
        .pll_ctl (pll_ctl),
        .oe_reg  (oe_reg),
        .req1_n  (req1_n),
        .req4_n  (req4_n),
        .bw_pin  (bw_pin),
        .out_en  (out_en),
        .bw_sel  (bw_sel),
        .pll_on  (pll_on)
    );

endmodule

// File: tb/sim_smb_clkbuf_ctrl.sv
module sim_smb_clkbuf_ctrl;

    localparam int H = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       req1_n = 1'b0;
    logic       req4_n = 1'b0;
    logic       bw_pin = 1'b0;
    logic       sda_oe;
    logic       sda_line;
    logic [5:0] out_en;
    logic       bw_sel;
    logic       pll_on;

    int checks = 0;
    int fails  = 0;
    bit cmp_on = 1'b0;
    bit done   = 1'b0;

    logic [7:0] mreg [0:5];
    logic [7:0] wbuf [0:7];

    assign sda_line = sda_m & ~sda_oe;

    smb_clkbuf_ctrl u0 (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl),
        .sda_in (sda_line),
        .sda_oe (sda_oe),
        .req1_n (req1_n),
        .req4_n (req4_n),
        .bw_pin (bw_pin),
        .out_en (out_en),
        .bw_sel (bw_sel),
        .pll_on (pll_on)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] mread(input int a);
        if (a == 3) return 8'h01;
        if (a == 4) return 8'h06;
        if (a >= 0 && a < 6) return mreg[a];
        return 8'h00;
    endfunction

    function automatic logic [7:0] exp_out();
        logic [5:0] e;
        logic b, p;
        e[0] = mreg[1][0];
        e[1] = ~req1_n;
        e[2] = mreg[1][2];
        e[3] = mreg[1][3];
        e[4] = ~req4_n;
        e[5] = mreg[1][5];
        b = mreg[0][7] ? mreg[0][1] : bw_pin;
        p = mreg[0][7] ? mreg[0][0] : 1'b1;
        return {p, b, e};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // R3 R4 R5: cycle-by-cycle comparison against the behavioural model
    always @(negedge clk) begin
        if (cmp_on && !rst && !done)
            check("R3 R4 R5 outputs", {24'd0, pll_on, bw_sel, out_en}, {24'd0, exp_out()});
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; tick(H);
        scl = 1'b1;   tick(H);
        sda_m = 1'b0; tick(H);
        scl = 1'b0;   tick(H);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(H);
        scl = 1'b1;   tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(H);
            scl = 1'b1;   tick(H);
            scl = 1'b0;
        end
        sda_m = 1'b1; tick(H);
        scl = 1'b1;   tick(H / 2);
        @(negedge clk);
        ack = ~sda_line;
        tick(H / 2);
        scl = 1'b0;
    endtask

    task automatic recv_byte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(H);
            scl = 1'b1; tick(H / 2);
            @(negedge clk);
            b[i] = sda_line;
            tick(H / 2);
            scl = 1'b0;
        end
        tick(2);
        sda_m = ~give_ack; tick(H);
        scl = 1'b1;        tick(H);
        scl = 1'b0;        tick(2);
        sda_m = 1'b1;
    endtask

    task automatic blk_write(input logic [7:0] cmd, input logic [7:0] cnt, input int n);
        logic ack;
        cmp_on = 1'b0;
        bus_start();
        send_byte(8'hDC, ack); check("R1 write address ack", ack, 1);
        send_byte(cmd, ack);   check("R8 command ack", ack, 1);
        send_byte(cnt, ack);   check("R8 count ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], ack);
            check("R8 data ack", ack, 1);
            if (i < int'(cnt)) begin
                int a = int'(cmd) + i;
                if (a == 0 || a == 1 || a == 2 || a == 5) mreg[a] = wbuf[i];
            end
        end
        bus_stop();
        tick(4);
        check("R11 released after stop", sda_oe, 0);
        cmp_on = 1'b1;
    endtask

    task automatic blk_read(input logic [7:0] cmd);
        logic ack;
        logic [7:0] b;
        int n;
        cmp_on = 1'b0;
        bus_start();
        send_byte(8'hDC, ack); check("R1 write address ack", ack, 1);
        send_byte(cmd, ack);   check("R9 command ack", ack, 1);
        bus_start();
        send_byte(8'hDD, ack); check("R1 read address ack", ack, 1);
        n = int'(mreg[5]);
        recv_byte(n != 0, b);
        check("R10 count byte first", b, mreg[5]);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, b);
            check("R9 read byte", b, mread(int'(cmd) + i));
        end
        bus_stop();
        tick(4);
        check("R11 released after stop", sda_oe, 0);
        cmp_on = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic ack;
        mreg[0] = 8'h03; mreg[1] = 8'h2D; mreg[2] = 8'h00;
        mreg[3] = 8'h01; mreg[4] = 8'h06; mreg[5] = 8'h06;
        tick(5);
        @(negedge clk) rst = 1'b0;
        tick(3);
        @(negedge clk);
        check("R2 reset out_en", out_en, 6'h3F);
        check("R2 reset pll_on", pll_on, 1);
        check("R2 reset bw_sel follows pin", bw_sel, 0);
        check("R11 idle sda_oe", sda_oe, 0);
        cmp_on = 1'b1;

        // R2 R9 R10: reset contents
        blk_read(8'h00);

        // R5 R3: pin paths with software control off
        tick(3); req1_n = 1'b1; tick(3);
        @(negedge clk); check("R5 out1 off when request high", out_en[1], 0);
        req4_n = 1'b1; bw_pin = 1'b1; tick(3);
        @(negedge clk); check("R5 out4 off when request high", out_en[4], 0);
        check("R3 bw follows pin", bw_sel, 1);
        req1_n = 1'b0; req4_n = 1'b0; tick(3);

        // R1: foreign address ignored
        cmp_on = 1'b0;
        bus_start();
        send_byte(8'hA0, ack); check("R1 foreign address nack", ack, 0);
        send_byte(8'h00, ack);
        send_byte(8'h01, ack);
        send_byte(8'h00, ack);
        bus_stop();
        cmp_on = 1'b1;
        blk_read(8'h00);

        // R3 R6: software control with reserved bits set
        wbuf[0] = 8'hFC;
        blk_write(8'h00, 8'd1, 1);
        @(negedge clk);
        check("R3 sw bw low", bw_sel, 0);
        check("R3 sw bypass", pll_on, 0);
        bw_pin = 1'b0; tick(3); bw_pin = 1'b1; tick(3);
        @(negedge clk); check("R3 pin ignored under sw control", bw_sel, 0);
        wbuf[0] = 8'h83;
        blk_write(8'h00, 8'd1, 1);
        @(negedge clk);
        check("R3 sw bw high", bw_sel, 1);
        check("R3 sw pll mode", pll_on, 1);

        // R4 R6: register enables and reserved bits
        wbuf[0] = 8'h00;
        blk_write(8'h01, 8'd1, 1);
        @(negedge clk); check("R4 enables cleared", out_en, 6'b010010);
        wbuf[0] = 8'hD2;
        blk_write(8'h01, 8'd1, 1);
        @(negedge clk); check("R6 reserved bits no effect", out_en, 6'b010010);
        blk_read(8'h00);

        // R7 R10 R8: multi-byte write over read-only registers and count
        wbuf[0] = 8'h5A; wbuf[1] = 8'h77; wbuf[2] = 8'h88; wbuf[3] = 8'h03;
        blk_write(8'h02, 8'd4, 4);
        check("R10 model count", mreg[5], 8'h03);
        blk_read(8'h02);
        // R9: read past the end of the bank
        blk_read(8'h04);

        // R8: surplus data bytes discarded
        wbuf[0] = 8'h11; wbuf[1] = 8'h22;
        blk_write(8'h02, 8'd1, 2);
        wbuf[0] = 8'h06;
        blk_write(8'h05, 8'd1, 1);
        blk_read(8'h00);

        // R8: write beyond the bank is dropped
        wbuf[0] = 8'hAA;
        blk_write(8'h07, 8'd1, 1);
        blk_read(8'h00);

        // R4: restore enables
        wbuf[0] = 8'h2D;
        blk_write(8'h01, 8'd1, 1);
        @(negedge clk); check("R4 enables restored", out_en, 6'h3F);
        tick(10);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule